// File: doc/BRIEF.md
# SDRAM Mode Word Decoder and Burst Column Sequencer

This block keeps the operating mode of a synchronous DRAM. It loads the mode from a 12-bit address bus and two bank bits when a mode-set strobe is high. It decodes four settings from that word: burst length, burst ordering, CAS latency and the single-write option. A word that carries any reserved or illegal content is refused and flagged, and the previous mode stays in force.

For every column command (read or write) the block produces the burst's column addresses on an 8-bit column bus, one per clock. The first address appears the cycle after the command. `burst_last` marks the final address. A controller uses the address stream to drive the column phase of its accesses. It uses the decoded CAS latency to place its data capture.

Top module: `sdram_burst_seq`

## Requirements
- R1: After a synchronous reset, `col_valid`, `burst_last` and `mode_err` are 0. The mode outputs show burst length 1, sequential order, CAS latency 2 and single-write off.
- R2: Mode address bits [2:0] set the burst length. 000, 001, 010 and 011 give 1, 2, 4 and 8. 111 gives a full page of 256 when bit 3 is 0. The codes 100, 101 and 110 are reserved.
- R3: Mode bit 3 selects the order: 0 is sequential and 1 is interleaved. Length code 111 together with bit 3 = 1 is reserved.
- R4: Mode bits [6:4] set the CAS latency. 010 gives 2 and 011 gives 3. Every other value is reserved.
- R5: On a strobe, a word is rejected if it has a reserved code, a nonzero bank bit, a nonzero bit 11 or 10, or a nonzero bit 8 or 7. A rejected word sets `mode_err` on the next cycle and leaves every mode output unchanged. An accepted word clears `mode_err` and updates the mode outputs on the next cycle.
- R6: In sequential order, address k of a burst of length L keeps the column bits above log2(L). Its low log2(L) bits equal (start + k) mod L.
- R7: In interleaved order, address k of a burst is the start column XOR k.
- R8: When mode bit 9 is 1, each write is a single column with `burst_last` high. Reads still use the programmed length.
- R9: A command sampled at a clock edge puts its start column on `col_addr` with `col_valid` high on the next cycle. One further address follows on each cycle, L addresses in total. `col_valid` then returns to 0.
- R10: `burst_last` is high on the final address of each burst and at no other time.
- R11: A command that arrives while a burst is running ends that burst at once. The new burst's start column is the very next address.
- R12: A burst keeps the length and order that were in force when its command was sampled. A mode strobe during the burst, or in the same cycle as the command, affects only later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_valid | input | 1 | Mode-set strobe |
| mrs_addr | input | 12 | Mode word from the address bus |
| mrs_bank | input | 2 | Bank bits at mode set (must be 0) |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 8 | Start column of the command |
| col_valid | output | 1 | Burst column address is valid |
| col_addr | output | 8 | Current burst column address |
| burst_last | output | 1 | Final address of the burst |
| mode_burst_len | output | 9 | Programmed burst length (1..256) |
| mode_interleave | output | 1 | 1 = interleaved order |
| mode_cas | output | 2 | CAS latency (2 or 3) |
| mode_single_write | output | 1 | Writes forced to one column |
| mode_err | output | 1 | Last mode word was rejected |

## Verification
Each burst is tried from start columns that sit away from the aligned block boundary, so that a wrong wrap or a carry into the upper bits shows as a wrong address. Sequential and interleaved bursts of the same length are run from starts that produce different address orders, which separates the two modes. A full-page burst is started mid-page to show the wrap through column 0. Reserved words are sent one kind at a time, so that each rejection cause is checked on its own. Commands are also issued mid-burst and next to mode strobes, which distinguishes termination and the snapshot of the mode from simple back-to-back operation.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Field positions inside the mode word (fixed by the command encoding)
  localparam int BL_LSB   = 0;
  localparam int ORD_BIT  = 3;
  localparam int CL_LSB   = 4;
  localparam int TM_LSB   = 7;
  localparam int SW_BIT   = 9;
  localparam int HI_LSB   = 10;

  localparam logic [2:0] BL_CODE_1    = 3'b000;
  localparam logic [2:0] BL_CODE_2    = 3'b001;
  localparam logic [2:0] BL_CODE_4    = 3'b010;
  localparam logic [2:0] BL_CODE_8    = 3'b011;
  localparam logic [2:0] BL_CODE_PAGE = 3'b111;
  localparam logic [2:0] CL_CODE_2    = 3'b010;
  localparam logic [2:0] CL_CODE_3    = 3'b011;

  typedef struct packed {
    logic [2:0] bl_code;
    logic       interleave;
    logic       cas3;
    logic       single_wr;
  } sbs_mode_t;

  localparam sbs_mode_t MODE_RESET = '{bl_code: BL_CODE_1, interleave: 1'b0,
                                       cas3: 1'b0, single_wr: 1'b0};

  // Burst length of a stored (already validated) length code
  function automatic int unsigned bl_len(input logic [2:0] code, input int unsigned col_w);
    case (code)
      BL_CODE_1: return 1;
      BL_CODE_2: return 2;
      BL_CODE_4: return 4;
      BL_CODE_8: return 8;
      default:   return 32'd1 << col_w;
    endcase
  endfunction

endpackage

// File: rtl/sbs_mode_dec.sv
module sbs_mode_dec
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic [ADDR_W-1:0] word,
  input  logic [BANK_W-1:0] bank,
  output sbs_mode_t         dec,
  output logic              bad
);

  logic [2:0] bl_f;
  logic [2:0] cl_f;
  logic       bl_ok;
  logic       cl_ok;
  logic       rsvd_ok;

  always_comb begin
    bl_f = word[BL_LSB +: 3];
    cl_f = word[CL_LSB +: 3];

    dec.bl_code    = bl_f;
    dec.interleave = word[ORD_BIT];
    dec.cas3       = (cl_f == CL_CODE_3);
    dec.single_wr  = word[SW_BIT];

    case (bl_f)
      BL_CODE_1, BL_CODE_2, BL_CODE_4, BL_CODE_8: bl_ok = 1'b1;
      BL_CODE_PAGE: bl_ok = !word[ORD_BIT];  // full page only in sequential order
      default:      bl_ok = 1'b0;
    endcase

    cl_ok   = (cl_f == CL_CODE_2) || (cl_f == CL_CODE_3);
    rsvd_ok = (word[TM_LSB +: 2] == 2'b00) &&
              (word[ADDR_W-1:HI_LSB] == '0) &&
              (bank == '0);

    bad = !(bl_ok && cl_ok && rsvd_ok);
  end

endmodule

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  sbs_mode_t dec,
  input  logic      bad,
  output sbs_mode_t mode_q,
  output logic      err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
      err_q  <= 1'b0;
    end else if (load) begin
      err_q <= bad;
      if (!bad) mode_q <= dec;
    end
  end

endmodule

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  sbs_mode_t        mode,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             burst_last
);

  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] mask_q;
  logic             inter_q;
  logic             active_q;

  logic [COL_W-1:0] new_mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] nxt_addr;

  // Length snapshot for the incoming command, as an all-ones low mask
  always_comb begin
    if (cmd_write && mode.single_wr) new_mask = '0;
    else new_mask = COL_W'(bl_len(mode.bl_code, COL_W) - 1);
  end

  assign sum = start_q + cnt_q;

  // Per column bit: held above the burst block, ordered within it
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign nxt_addr[i] = mask_q[i] ? (inter_q ? (start_q[i] ^ cnt_q[i]) : sum[i])
                                   : start_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q    <= '0;
      cnt_q      <= '0;
      mask_q     <= '0;
      inter_q    <= 1'b0;
      active_q   <= 1'b0;
      col_valid  <= 1'b0;
      col_addr   <= '0;
      burst_last <= 1'b0;
    end else if (cmd_valid) begin
      start_q    <= cmd_col;
      cnt_q      <= COL_W'(1);
      mask_q     <= new_mask;
      inter_q    <= mode.interleave;
      active_q   <= (new_mask != '0);
      col_valid  <= 1'b1;
      col_addr   <= cmd_col;
      burst_last <= (new_mask == '0);
    end else if (active_q) begin
      cnt_q      <= cnt_q + COL_W'(1);
      active_q   <= (cnt_q != mask_q);
      col_valid  <= 1'b1;
      col_addr   <= nxt_addr;
      burst_last <= (cnt_q == mask_q);
    end else begin
      col_valid  <= 1'b0;
      burst_last <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  localparam int LEN_W = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_valid,
  input  logic [ADDR_W-1:0] mrs_addr,
  input  logic [BANK_W-1:0] mrs_bank,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              burst_last,
  output logic [LEN_W-1:0]  mode_burst_len,
  output logic              mode_interleave,
  output logic [1:0]        mode_cas,
  output logic              mode_single_write,
  output logic              mode_err
);

  sbs_mode_t dec_w;
  sbs_mode_t mode_w;
  logic      bad_w;

  sbs_mode_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) dec_i (
    .word (mrs_addr),
    .bank (mrs_bank),
    .dec  (dec_w),
    .bad  (bad_w)
  );

  sbs_mode_reg reg_i (
    .clk    (clk),
    .rst    (rst),
    .load   (mrs_valid),
    .dec    (dec_w),
    .bad    (bad_w),
    .mode_q (mode_w),
    .err_q  (mode_err)
  );

  sbs_burst_gen #(.COL_W(COL_W)) gen_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_col    (cmd_col),
    .mode       (mode_w),
    .col_valid  (col_valid),
    .col_addr   (col_addr),
    .burst_last (burst_last)
  );

  assign mode_burst_len    = LEN_W'(bl_len(mode_w.bl_code, COL_W));
  assign mode_interleave   = mode_w.interleave;
  assign mode_cas          = mode_w.cas3 ? 2'd3 : 2'd2;
  assign mode_single_write = mode_w.single_wr;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mrs_valid,
  input logic [ADDR_W-1:0] mrs_addr,
  input logic [BANK_W-1:0] mrs_bank,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [COL_W-1:0]  cmd_col,
  input logic              col_valid,
  input logic [COL_W-1:0]  col_addr,
  input logic              burst_last,
  input logic [COL_W:0]    mode_burst_len,
  input logic              mode_interleave,
  input logic [1:0]        mode_cas,
  input logic              mode_single_write,
  input logic              mode_err
);

  p_first_addr_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

  p_last_qual_r10: assert property (@(posedge clk) disable iff (rst)
    burst_last |-> col_valid);

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !mrs_valid |=> ($stable(mode_err) && $stable(mode_burst_len) &&
                    $stable(mode_interleave) && $stable(mode_cas) &&
                    $stable(mode_single_write)));

  p_bank_reject_r5: assert property (@(posedge clk) disable iff (rst)
    (mrs_valid && mrs_bank != '0) |=> (mode_err && $stable(mode_burst_len) &&
                                      $stable(mode_cas) && $stable(mode_interleave)));

  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && mode_single_write) |=> burst_last);

  p_len_pow2_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_burst_len) == 1);

  p_cas_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_cas == 2'd2 || mode_cas == 2'd3));

  p_page_seq_r3: assert property (@(posedge clk) disable iff (rst)
    mode_burst_len[COL_W] |-> !mode_interleave);

endmodule

bind sdram_burst_seq sbs_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .COL_W(COL_W)) chk_i (
  .clk               (clk),
  .rst               (rst),
  .mrs_valid         (mrs_valid),
  .mrs_addr          (mrs_addr),
  .mrs_bank          (mrs_bank),
  .cmd_valid         (cmd_valid),
  .cmd_write         (cmd_write),
  .cmd_col           (cmd_col),
  .col_valid         (col_valid),
  .col_addr          (col_addr),
  .burst_last        (burst_last),
  .mode_burst_len    (mode_burst_len),
  .mode_interleave   (mode_interleave),
  .mode_cas          (mode_cas),
  .mode_single_write (mode_single_write),
  .mode_err          (mode_err)
);

// File: tb/sdram_burst_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mrs_valid = 1'b0;
  logic [11:0] mrs_addr = '0;
  logic [1:0]  mrs_bank = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [7:0]  cmd_col = '0;
  logic        col_valid;
  logic [7:0]  col_addr;
  logic        burst_last;
  logic [8:0]  mode_burst_len;
  logic        mode_interleave;
  logic [1:0]  mode_cas;
  logic        mode_single_write;
  logic        mode_err;

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  // bench model of the mode in force
  int m_len = 1;
  bit m_inter = 1'b0;
  int m_cas = 2;
  bit m_single = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sdram_burst_seq dut_i (
    .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mrs_addr(mrs_addr), .mrs_bank(mrs_bank),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .col_valid(col_valid), .col_addr(col_addr), .burst_last(burst_last),
    .mode_burst_len(mode_burst_len), .mode_interleave(mode_interleave), .mode_cas(mode_cas),
    .mode_single_write(mode_single_write), .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input logic [7:0] s, input int k, input int len, input bit inter);
    logic [7:0] m;
    logic [7:0] kk;
    m  = 8'(len - 1);
    kk = 8'(k);
    if (inter) return s ^ kk;
    return (s & ~m) | ((s + kk) & m);
  endfunction

  task automatic push_burst(input logic [7:0] s, input int len, input bit inter, input string tag);
    exp_q.delete();
    tag_q.delete();
    for (int k = 0; k < len; k++) begin
      exp_q.push_back({(k == len - 1), exp_addr(s, k, len, inter)});
      tag_q.push_back(tag);
    end
  endtask

  task automatic issue_cmd(input bit wr, input logic [7:0] col, input string tag);
    int len;
    @(negedge clk);
    len = (wr && m_single) ? 1 : m_len;
    push_burst(col, len, m_inter, tag);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = col;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_mode(input bit e_err, input string tag);
    check(mode_err == e_err, tag, "mode_err", int'(mode_err), int'(e_err));
    check(mode_burst_len == 9'(m_len), tag, "burst_len", int'(mode_burst_len), m_len);
    check(mode_interleave == m_inter, tag, "interleave", int'(mode_interleave), int'(m_inter));
    check(int'(mode_cas) == m_cas, tag, "cas", int'(mode_cas), m_cas);
    check(mode_single_write == m_single, tag, "single_write", int'(mode_single_write), int'(m_single));
  endtask

  // accepted word: model takes the given mode
  task automatic mrs_good(input logic [11:0] a, input int len, input bit inter, input int cas,
                          input bit single, input string tag);
    @(negedge clk);
    mrs_valid = 1'b1; mrs_addr = a; mrs_bank = 2'b00;
    @(negedge clk);
    mrs_valid = 1'b0;
    m_len = len; m_inter = inter; m_cas = cas; m_single = single;
    check_mode(1'b0, tag);
  endtask

  // rejected word: model unchanged
  task automatic mrs_bad(input logic [11:0] a, input logic [1:0] b, input string tag);
    @(negedge clk);
    mrs_valid = 1'b1; mrs_addr = a; mrs_bank = b;
    @(negedge clk);
    mrs_valid = 1'b0; mrs_bank = 2'b00;
    check_mode(1'b1, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_en && col_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected col_valid", int'(col_addr), 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(col_addr == e[7:0], t, "col_addr", int'(col_addr), int'(e[7:0]));
          check(burst_last == e[8], {t, "/R10"}, "burst_last", int'(burst_last), int'(e[8]));
        end
      end else if (mon_en && burst_last) begin
        check(1'b0, "R10", "burst_last without col_valid", 1, 0);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "run did not complete", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(col_valid == 1'b0, "R1", "col_valid", int'(col_valid), 0);
    check(burst_last == 1'b0, "R1", "burst_last", int'(burst_last), 0);
    check_mode(1'b0, "R1");
    rst = 1'b0;
    mon_en = 1'b1;
    repeat (2) @(negedge clk);

    // R9 R10: default length 1
    issue_cmd(1'b0, 8'h35, "R9");
    drain();

    // R2 R4: length 4 sequential, CAS 3
    mrs_good(12'h032, 4, 1'b0, 3, 1'b0, "R2");
    issue_cmd(1'b0, 8'h3E, "R6");
    drain();
    issue_cmd(1'b1, 8'h3E, "R6");  // write without single-write bursts fully
    drain();

    // R3 R7: interleave length 8 and 4
    mrs_good(12'h02B, 8, 1'b1, 2, 1'b0, "R3");
    issue_cmd(1'b0, 8'h45, "R7");
    drain();
    mrs_good(12'h02A, 4, 1'b1, 2, 1'b0, "R3");
    issue_cmd(1'b0, 8'h06, "R7");
    drain();

    // R2 R11: full page, truncated then restarted mid-page (wraps through 0)
    mrs_good(12'h037, 256, 1'b0, 3, 1'b0, "R2");
    issue_cmd(1'b0, 8'h10, "R11");
    @(negedge clk);
    issue_cmd(1'b0, 8'h80, "R11");
    drain();

    // R5 rejections, one cause each
    mrs_bad(12'h03F, 2'b00, "R3");  // page + interleave
    mrs_bad(12'h011, 2'b00, "R4");  // CAS code 001
    mrs_bad(12'h024, 2'b00, "R2");  // length code 100
    mrs_bad(12'h032, 2'b01, "R5");  // bank bit
    mrs_bad(12'h0B2, 2'b00, "R5");  // test field
    mrs_bad(12'h832, 2'b00, "R5");  // high reserved bit

    // R8: single write, reads still burst
    mrs_good(12'h232, 4, 1'b0, 3, 1'b1, "R8");
    issue_cmd(1'b1, 8'h20, "R8");
    drain();
    issue_cmd(1'b0, 8'h21, "R8");
    drain();

    // R12: mode strobe during a burst
    mrs_good(12'h032, 4, 1'b0, 3, 1'b0, "R12");
    issue_cmd(1'b0, 8'h08, "R12");
    mrs_good(12'h021, 2, 1'b0, 2, 1'b0, "R12");
    drain();

    // R12: strobe and command in the same cycle, command uses old length 2
    @(negedge clk);
    push_burst(8'h1B, 2, 1'b0, "R12");
    mrs_valid = 1'b1; mrs_addr = 12'h033; cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'h1B;
    @(negedge clk);
    mrs_valid = 1'b0; cmd_valid = 1'b0;
    m_len = 8; m_cas = 3;
    check_mode(1'b0, "R12");
    drain();

    check(exp_q.size() == 0, "R9", "missing addresses", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule